// File: doc/BRIEF.md
# Sequential Integer Multiplier with Shift-Add and Booth Modes

This block multiplies two N-bit integers over N clock steps using a single N-bit adder/subtractor. Its only data store is one 2N-bit product register. The upper half of that register is the running accumulator. The lower half starts out holding the multiplier, and the product bits shift into it as the multiplier bits shift out.

A select input chooses how each step is decided:
- **Unsigned mode:** each step is a plain shift-add, decided by the lowest product bit.
- **Signed mode:** each step uses radix-2 Booth recoding. It looks at the lowest product bit together with the bit shifted out on the previous step, and then adds, subtracts or does nothing.

In both modes the adder result is one bit wider than the operands. The extra bit is the carry-out in unsigned mode and the sign in signed mode. It is shifted into the top of the register, so no sum bit is lost. This includes the most negative multiplicand.

The block is driven with plain control pins:
- Raise `start` for a cycle while `busy` is low, with both operands and the mode select valid. The block captures all three on that edge and raises `busy`.
- N steps later, `busy` falls and `done` pulses for one cycle.
- The high and low result words stay on `prod_hi` and `prod_lo` until the next accepted start.
- A `start` raised while `busy` is high is dropped. There is no back-pressure or queueing.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `prod_hi` and `prod_lo` are all zeros.
- R2: A `start` sampled high while `busy` is low captures `mcand_i`, `mplier_i` and `signed_mode`, and `busy` is high from the next cycle.
- R3: With `signed_mode` = 0, {`prod_hi`,`prod_lo`} at `done` equals the unsigned 2N-bit product of the two operands, for example 4-bit 2 × 3 = 0x06 and 15 × 15 = 0xE1.
- R4: With `signed_mode` = 1, {`prod_hi`,`prod_lo`} at `done` equals the two's-complement 2N-bit product, for example 4-bit 2 × −3 = 0xFA and 2 × 7 = 0x0E.
- R5: In signed mode, an operand equal to −2^(N−1) gives the correct product, for example 4-bit −8 × −8 = 0x40 and −8 × 7 = 0xC8.
- R6: `done` goes high at the (N+1)th rising edge counting the edge that accepted `start`. This is exactly N step cycles.
- R7: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R8: After `done`, the result stays unchanged while no start is accepted, even if the operand inputs change.
- R9: A `start` raised while `busy` is high is ignored. The running operation keeps its operands, mode and timing.
- R10: `signed_mode` changing while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; taken only while idle |
| signed_mode | input | 1 | 1 = signed Booth steps, 0 = unsigned shift-add steps |
| mcand_i | input | N | Multiplicand |
| mplier_i | input | N | Multiplier |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse when the result is complete |
| prod_hi | output | N | Upper word of the 2N-bit product |
| prod_lo | output | N | Lower word of the 2N-bit product |

## Verification
The bench runs every 4-bit operand pair in both modes against a product computed by integer arithmetic. This covers several failure modes:
- If the adder were only N bits wide, unsigned products with a carry-out (15 × 15) would come out wrong. So would signed products with a −8 multiplicand, where the subtract overflows.
- A logical shift in Booth mode would show up as wrong negative results.
- A Booth pair history that did not start at 0 would corrupt any product with an odd multiplier.

Directed cases check the following:
- The step count is exactly N. An extra or missing iteration would halve or double the result, or move `done`.
- `done` is a single-cycle pulse.
- The result holds while the operand inputs wander.
- A mid-run `start` and a mid-run mode flip are both ignored. A design that re-latched on either would return the second operands' product or a mixed-mode result.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2
  } step_op_e;
endpackage

// File: rtl/mul_step_decode.sv
module mul_step_decode
  import mul_pkg::*;
(
  input  logic     booth_i,
  input  logic     lsb_i,
  input  logic     prev_i,
  output step_op_e op_o
);
  always_comb begin
    op_o = OP_NOP;
    if (booth_i) begin
      case ({lsb_i, prev_i})
        2'b10:   op_o = OP_SUB;
        2'b01:   op_o = OP_ADD;
        default: op_o = OP_NOP;
      endcase
    end else if (lsb_i) begin
      op_o = OP_ADD;
    end
  end
endmodule

// File: rtl/mul_addsub.sv
module mul_addsub
  import mul_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] acc_i,
  input  logic [N-1:0] addend_i,
  input  logic         sext_i,
  input  step_op_e     op_i,
  output logic [N:0]   res_o
);
  logic [N:0] acc_x;
  logic [N:0] add_x;

  assign acc_x = {sext_i & acc_i[N-1], acc_i};
  assign add_x = {sext_i & addend_i[N-1], addend_i};

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = acc_x + add_x;
      OP_SUB:  res_o = acc_x - add_x;
      default: res_o = acc_x;
    endcase
  end
endmodule

// File: rtl/mul_step_ctr.sv
module mul_step_ctr #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  output logic last_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import mul_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] prod_hi,
  output logic [N-1:0] prod_lo
);
  localparam int PW = 2 * N;

  logic [PW-1:0] prod_q;
  logic [N-1:0]  mcand_q;
  logic          prev_q;
  logic          booth_q;
  logic          busy_q;
  logic          done_q;

  logic          accept;
  logic          last;
  step_op_e      op;
  logic [N:0]    step_res;

  assign accept = start && !busy_q;

  mul_step_decode u_dec (
    .booth_i (booth_q),
    .lsb_i   (prod_q[0]),
    .prev_i  (prev_q),
    .op_o    (op)
  );

  mul_addsub #(.N(N)) u_alu (
    .acc_i    (prod_q[PW-1:N]),
    .addend_i (mcand_q),
    .sext_i   (booth_q),
    .op_i     (op),
    .res_o    (step_res)
  );

  mul_step_ctr #(.N(N)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .adv_i  (busy_q),
    .last_o (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
      prev_q  <= 1'b0;
      booth_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        prod_q <= {step_res, prod_q[N-1:1]};
        prev_q <= prod_q[0];
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        prod_q  <= {{N{1'b0}}, mplier_i};
        mcand_q <= mcand_i;
        booth_q <= signed_mode;
        prev_q  <= 1'b0;
        busy_q  <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prod_hi = prod_q[PW-1:N];
  assign prod_lo = prod_q[N-1:0];
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         signed_mode,
  input logic [N-1:0] mcand_i,
  input logic [N-1:0] mplier_i,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] prod_hi,
  input logic [N-1:0] prod_lo
);
  localparam int PW = 2 * N;
  localparam int SW = $clog2(N + 1) + 1;

  logic [N-1:0]  a_q;
  logic [N-1:0]  b_q;
  logic          m_q;
  logic [SW-1:0] steps_q;
  logic [PW-1:0] ea;
  logic [PW-1:0] eb;
  logic [PW-1:0] ref_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      m_q     <= 1'b0;
      steps_q <= '0;
    end else if (start && !busy) begin
      a_q     <= mcand_i;
      b_q     <= mplier_i;
      m_q     <= signed_mode;
      steps_q <= '0;
    end else if (busy) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  assign ea       = {{N{m_q & a_q[N-1]}}, a_q};
  assign eb       = {{N{m_q & b_q[N-1]}}, b_q};
  assign ref_prod = ea * eb;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({prod_hi, prod_lo} == ref_prod)); // R3
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (steps_q == SW'(N))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo))); // R8
  AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy || done)); // R9
endmodule

bind seq_mul seq_mul_chk #(.N(N)) u_chk (.*);

// File: tb/tb_seq_mul.sv
module tb_seq_mul;
  localparam int W  = 4;
  localparam int PW = 2 * W;
  localparam int NV = 11;

  // {signed_mode, mcand, mplier, expected product}
  localparam logic [1+W+W+PW-1:0] VEC [NV] = '{
    {1'b0, 4'h2, 4'h3, 8'h06},
    {1'b1, 4'h2, 4'hD, 8'hFA},
    {1'b1, 4'h2, 4'h7, 8'h0E},
    {1'b0, 4'hF, 4'hF, 8'hE1},
    {1'b0, 4'h8, 4'hF, 8'h78},
    {1'b0, 4'h0, 4'hF, 8'h00},
    {1'b1, 4'h8, 4'h8, 8'h40},
    {1'b1, 4'h8, 4'h7, 8'hC8},
    {1'b1, 4'h7, 4'h8, 8'hC8},
    {1'b1, 4'hF, 4'hF, 8'h01},
    {1'b1, 4'h8, 4'h1, 8'hF8}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] prod_hi;
  logic [W-1:0] prod_lo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  seq_mul #(.N(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .mcand_i(mcand_i), .mplier_i(mplier_i), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic m, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    int x, y;
    x = int'(a);
    y = int'(b);
    if (m && a[W-1]) x = x - (1 << W);
    if (m && b[W-1]) y = y - (1 << W);
    return PW'(x * y);
  endfunction

  // drive one operation from a negedge; returns result and edge count to done
  task automatic run_op(input logic m, input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [PW-1:0] res, output int edges);
    signed_mode = m;
    mcand_i     = a;
    mplier_i    = b;
    start       = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 50) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    res = {prod_hi, prod_lo};
  endtask

  initial begin
    logic [PW-1:0] r;
    int            e;

    repeat (3) @(negedge clk);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 result", longint'({prod_hi, prod_lo}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][16], VEC[i][15:12], VEC[i][11:8], r, e);
      chk(VEC[i][16] ? "R4/R5 table" : "R3 table", longint'(r), longint'(VEC[i][7:0]));
      @(negedge clk);
    end

    // R2 / R6 / R7: timing and pulse shape
    signed_mode = 1'b0; mcand_i = 4'h5; mplier_i = 4'h3; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", longint'(busy), 1);
    e = 1;
    while (!done && e < 50) begin
      @(posedge clk);
      @(negedge clk);
      e++;
    end
    chk("R6 edges to done", longint'(e), longint'(W + 1));
    chk("R7 busy low with done", longint'(busy), 0);
    chk("R3 5x3", longint'({prod_hi, prod_lo}), 15);
    @(negedge clk);
    chk("R7 done one cycle", longint'(done), 0);

    // R8: hold while inputs wander
    mcand_i = 4'hA; mplier_i = 4'h9; signed_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 result held", longint'({prod_hi, prod_lo}), 15);

    // R9 / R10: mid-run start and mode flip ignored
    signed_mode = 1'b0; mcand_i = 4'hE; mplier_i = 4'h3; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mcand_i = 4'h7; mplier_i = 4'h7; start = 1'b1; signed_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 3;
    while (!done && e < 50) begin
      @(posedge clk);
      @(negedge clk);
      e++;
    end
    chk("R9 edges unchanged", longint'(e), longint'(W + 1));
    chk("R10 unsigned result kept", longint'({prod_hi, prod_lo}), 42);
    signed_mode = 1'b0;
    @(negedge clk);

    // exhaustive in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          run_op(m[0], W'(a), W'(b), r, e);
          chk(m != 0 ? "R4 sweep" : "R3 sweep", longint'(r),
              longint'(ref_mul(m[0], W'(a), W'(b))));
          if (e != W + 1) chk("R6 sweep edges", longint'(e), longint'(W + 1));
        end
      end
    end

    // R1: reset mid-run clears state
    signed_mode = 1'b1; mcand_i = 4'h9; mplier_i = 4'h9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset busy", longint'(busy), 0);
    chk("R1 reset result", longint'({prod_hi, prod_lo}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule